// File: doc/BRIEF.md
# Keyed Security Bit Register

This block holds one security flag on a 32-bit write bus. The flag comes out of power-on reset set to 1. It changes only through a two-step unlock. First the host writes a fixed 32-bit key to the register address as a full-word transfer. Then, inside a short window of clock edges, it writes the new value. Bit 0 of that second word becomes the flag.

Narrow transfers, the wrong first word, a late second write, and any attempt made in an operating mode that may not update the flag are all refused. Each refused addressed write raises a one-cycle reject pulse. While the block waits for the second write, it shows an armed flag.

The write side is a plain strobe with size and address-hit qualifiers. It is not a valid/ready stream and applies no back-pressure: the block accepts or refuses every write in the cycle it is presented. Every update needs a fresh key, because a completed update disarms the sequence.

Top module: `sbk_top`

## Requirements
- R1: An addressed full-word write of 0xA74A9D23, made while not armed and in an allowed mode, sets `armed` high from the next clock edge, with no reject pulse.
- R2: While armed, a data write sampled on any of the 16 clock edges after the key edge is accepted. If no addressed write arrives, `armed` falls on the 16th edge, and a write on the 17th edge is refused.
- R3: `wr_size` encodes 00 as byte, 01 as halfword, 10 as word and 11 as reserved. Only 10 counts as full-word. Any other size neither arms nor commits. A narrow addressed write while armed is refused and disarms.
- R4: `op_mode` 00 (single-chip) and 01 (single-boot) allow updates. With 10 or 11, every addressed write is refused and `sec_bit` does not change.
- R5: After reset, `sec_bit` is 1, `armed` is 0 and `reject` is 0.
- R6: An accepted data write loads `wr_data[0]` into `sec_bit` on that clock edge and clears `armed`. A further update needs a new key.
- R7: `reject` is high for exactly the one cycle after each addressed write that neither arms nor commits. This includes a non-key write while not armed. It is low otherwise.
- R8: A write with `addr_hit` low changes nothing and gives no reject pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | Transfer size: 00 byte, 01 half, 10 word, 11 reserved |
| addr_hit | input | 1 | Write targets this register |
| wr_data | input | 32 | Write data |
| op_mode | input | 2 | Operating mode: 00 single-chip, 01 single-boot, others locked |
| sec_bit | output | 1 | Security flag |
| armed | output | 1 | Key accepted, waiting for data write |
| reject | output | 1 | One-cycle pulse for a refused write |

## Verification
The unlock is tried with the following patterns:

- A key followed at once by data.
- Data on the last edge of the window, and one edge past it.
- Wrong keys and data with no key.
- Byte, halfword and reserved sizes on both the key step and the data step.
- Locked modes.
- Writes with the address hit low.

Writing both 0 and 1 as data shows that bit 0 really drives the flag. The window-edge pair separates an off-by-one window from a correct one. The pairs of narrow-size and locked-mode writes show that refused writes both pulse `reject` and leave the flag and the armed state as the requirements state.

// File: rtl/sbk_pkg.sv
package sbk_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hA74A9D23;
  localparam int unsigned WINDOW = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    MD_CHIP = 2'b00,
    MD_BOOT = 2'b01,
    MD_LCK2 = 2'b10,
    MD_LCK3 = 2'b11
  } mode_e;

  typedef struct packed {
    logic hit;
    logic full;
    logic mode_ok;
    logic key_match;
  } wr_qual_t;
endpackage

// File: rtl/sbk_qual.sv
module sbk_qual
  import sbk_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter logic [DW-1:0] KEY = UNLOCK_KEY
) (
  input  logic          wr_en,
  input  logic [1:0]    wr_size,
  input  logic          addr_hit,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    op_mode,
  output wr_qual_t      qual
);
  always_comb begin
    qual.hit       = wr_en & addr_hit;
    qual.full      = (wr_size == SZ_WORD);
    qual.mode_ok   = (op_mode == MD_CHIP) || (op_mode == MD_BOOT);
    qual.key_match = (wr_data == KEY);
  end
endmodule

// File: rtl/sbk_window.sv
module sbk_window #(
  parameter int unsigned WIN = 16,
  localparam int unsigned CW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic consume,
  output logic armed
);
  logic [CW-1:0] cnt;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (armed) begin
      if (consume || cnt == LAST) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbk_top.sv
module sbk_top
  import sbk_pkg::*;
#(
  parameter int unsigned WIN = WINDOW
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_size,
  input  logic        addr_hit,
  input  logic [31:0] wr_data,
  input  logic [1:0]  op_mode,
  output logic        sec_bit,
  output logic        armed,
  output logic        reject
);
  wr_qual_t q;
  logic ok, arm, commit, consume;

  sbk_qual #(.DW(32), .KEY(UNLOCK_KEY)) u_qual (
    .wr_en(wr_en), .wr_size(wr_size), .addr_hit(addr_hit),
    .wr_data(wr_data), .op_mode(op_mode), .qual(q)
  );

  assign ok      = q.hit & q.full & q.mode_ok;
  assign arm     = ~armed & ok & q.key_match;
  assign commit  = armed & ok;
  assign consume = armed & q.hit;

  sbk_window #(.WIN(WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .arm(arm), .consume(consume), .armed(armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_bit <= 1'b1;
      reject  <= 1'b0;
    end else begin
      if (commit) sec_bit <= wr_data[0];
      reject <= q.hit & ~(arm | commit);
    end
  end
endmodule

// File: rtl/sbk_checker.sv
module sbk_checker #(
  parameter int unsigned WIN = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_size,
  input logic        addr_hit,
  input logic [31:0] wr_data,
  input logic [1:0]  op_mode,
  input logic        sec_bit,
  input logic        armed,
  input logic        reject
);
  logic hit, full, mode_ok;
  logic [$clog2(WIN)+1:0] run;
  assign hit     = wr_en & addr_hit;
  assign full    = (wr_size == 2'b10);
  assign mode_ok = ~op_mode[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= armed ? run + 1'b1 : '0;
  end

  a_r1_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && hit && full && mode_ok && wr_data == 32'hA74A9D23) |=> (armed && !reject));

  a_r2_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (run < WIN));

  a_r3_narrow_keeps_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !full) |=> ($stable(sec_bit) && reject));

  a_r4_locked_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !mode_ok) |=> ($stable(sec_bit) && reject && !armed));

  a_r6_data_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && hit) |=> !armed);

  a_r7_non_key_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && hit && wr_data != 32'hA74A9D23) |=> (reject && $stable(sec_bit)));

  a_r8_no_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !reject);
endmodule

bind sbk_top sbk_checker #(.WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size),
  .addr_hit(addr_hit), .wr_data(wr_data), .op_mode(op_mode),
  .sec_bit(sec_bit), .armed(armed), .reject(reject)
);

// File: tb/sbk_top_tb.sv
module sbk_top_tb;
  localparam logic [31:0] KEY = 32'hA74A9D23;
  logic clk = 0, rst_n = 0, wr_en = 0, addr_hit = 0;
  logic [1:0] wr_size = 2'b10, op_mode = 2'b00;
  logic [31:0] wr_data = '0;
  logic sec_bit, armed, reject;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sbk_top u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size),
    .addr_hit(addr_hit), .wr_data(wr_data), .op_mode(op_mode),
    .sec_bit(sec_bit), .armed(armed), .reject(reject));

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {sec,armed,reject} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] st();
    return {sec_bit, armed, reject};
  endfunction

  task automatic wr(logic [1:0] sz, logic [31:0] d, logic hit = 1'b1);
    wr_en = 1; addr_hit = hit; wr_size = sz; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0; addr_hit = 0; wr_size = 2'b10; wr_data = '0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic t_reset();
    chk("R5 reset state", st(), 3'b100);
  endtask

  task automatic t_basic();
    wr(2'b10, KEY);    chk("R1 key arms", st(), 3'b110);
    wr(2'b10, 32'h0);  chk("R6 data clears bit", st(), 3'b000);
    wr(2'b10, 32'h1);  chk("R7 data without key refused", st(), 3'b001);
    wr(2'b10, KEY);    wr(2'b10, 32'hFFFF_FFFF);
    chk("R6 data sets bit", st(), 3'b100);
  endtask

  task automatic t_window();
    wr(2'b10, KEY); idle(15);
    chk("R2 still armed after 15 edges", st(), 3'b110);
    wr(2'b10, 32'h0);
    chk("R2 write on 16th edge accepted", st(), 3'b000);
    wr(2'b10, KEY); idle(15);
    chk("R2 armed at 15 edges", st(), 3'b010);
    idle(1);
    chk("R2 window expires on 16th edge", st(), 3'b000);
    wr(2'b10, 32'h1);
    chk("R2 late write refused", st(), 3'b001);
  endtask

  task automatic t_bad_key();
    wr(2'b10, KEY ^ 32'h1);
    chk("R7 wrong key refused", st(), 3'b001);
    idle(1);
    chk("R7 reject is one cycle", st(), 3'b000);
  endtask

  task automatic t_narrow();
    wr(2'b00, KEY); chk("R3 byte key does not arm", st(), 3'b001);
    wr(2'b11, KEY); chk("R3 reserved size does not arm", st(), 3'b001);
    wr(2'b10, KEY); wr(2'b01, 32'h1);
    chk("R3 half data refused and disarms", st(), 3'b001);
    wr(2'b10, 32'h1);
    chk("R3 follow-up needs new key", st(), 3'b001);
  endtask

  task automatic t_mode();
    op_mode = 2'b01;
    wr(2'b10, KEY); wr(2'b10, 32'h1);
    chk("R4 single-boot allowed", st(), 3'b100);
    op_mode = 2'b10;
    wr(2'b10, KEY); chk("R4 locked mode key refused", st(), 3'b101);
    wr(2'b10, 32'h0); chk("R4 locked mode bit unchanged", st(), 3'b101);
    op_mode = 2'b00;
    wr(2'b10, KEY); op_mode = 2'b11; wr(2'b10, 32'h0);
    chk("R4 mode change before data refused", st(), 3'b101);
    op_mode = 2'b00;
  endtask

  task automatic t_nohit();
    wr(2'b10, KEY, 1'b0);
    chk("R8 unaddressed key ignored", st(), 3'b100);
    wr(2'b10, KEY); wr(2'b10, 32'h0, 1'b0);
    chk("R8 unaddressed data ignored", st(), 3'b110);
    wr(2'b10, 32'h0);
    chk("R8 real data still accepted", st(), 3'b000);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    idle(3); t_reset();
    rst_n = 1; idle(1);
    t_reset();
    t_basic(); t_window(); t_bad_key(); t_narrow(); t_mode(); t_nohit();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule